// File: doc/BRIEF.md
# Alternate-Space Register Access Checker

This block sits beside the load/store path and screens accesses that target internal registers selected by an address-space code rather than ordinary memory. It serves three kinds of register window: a bank of scratch registers (reachable through two space codes, one ordinary and one intended for hypervisor software), a small bank of interrupt-queue head/tail registers, and the MMU identity registers (primary context, secondary context, partition identifier). For each request it looks at the space code, the byte offset and the privileged and hypervisor mode flags. It then either grants the access and performs it on the register file, raises a fault of the correct class, or flags an error for a space or offset it does not serve.

Each request is accepted in the cycle it is presented. The verdict appears on the response port exactly one cycle later. A fault also updates a fault-status record. The register file behind the checker is a plain array of 64-bit registers. Offset ranges and the privilege rule decide which slot is written or read.

Control is a four-state machine: `ST_IDLE` (no response pending), `ST_GRANT` (a granted access is being reported), `ST_FAULT` (a privileged-action or data-access fault is being reported) and `ST_ERROR` (an unsupported space or offset is being reported). From every state, a cycle without a request goes to `ST_IDLE`. A request whose verdict is legal goes to `ST_GRANT`. A request whose verdict is a privileged-action or data-access fault goes to `ST_FAULT`. A request whose verdict is unsupported goes to `ST_ERROR`. Back-to-back requests therefore move directly between the three reporting states.

Top module: `altspace_reg_gate`

## Requirements
- R1: A request (`req_valid`=1) produces a response (`rsp_valid`=1) in the next cycle, and a cycle without a request produces none. Each response carries exactly one of: grant (`rsp_grant`), fault (`rsp_fault_kind` nonzero) or error (`rsp_error`).
- R2: Space code 0 (scratch) grants any offset up to 0x38 outside 0x20–0x2F, in any mode. The slot is offset >> 3, so low offset bits below bit 3 are ignored.
- R3: In scratch space, offsets 0x20 through 0x2F are granted only when `req_hpriv`=1. Otherwise the access faults with kind 2 (data-access exception).
- R4: In scratch space, any offset above 0x38 faults with kind 2, whatever the mode.
- R5: Space code 2 (queue) with both `req_priv`=0 and `req_hpriv`=0 faults with kind 1 (privileged action), whatever the offset.
- R6: A queue access that passes the mode rule faults with kind 2 in any of these cases: the offset is below 0x3C0; the offset is above 0x3F8; or `req_priv`=1 and the offset is not a multiple of 16.
- R7: A granted queue access uses slot (offset >> 4) − 0x3C, so slots 0 to 3 are reached.
- R8: Space code 3 (MMU) maps offset 0x08 to the primary context and offset 0x10 to the secondary context. Space code 4 (data MMU) maps offset 0x80 to the partition identifier. Any other offset in these two spaces gives `rsp_error`=1.
- R9: Space codes 5, 6 and 7 always give `rsp_error`=1.
- R10: On each fault, the status outputs take these values in the cycle the fault is reported: `fs_valid`=1, `fs_ctx`=0 (primary), `fs_side`=1, `fs_type`=4'h8 (illegal space), and `fs_write` equal to the request's write flag. Grants and errors leave the status outputs unchanged.
- R11: A granted write stores `req_wdata` in the selected register. A granted read returns the register's content on `rsp_rdata`. Every other response returns 0 on `rsp_rdata`. A faulting or erroring write changes no register.
- R12: Space code 1 (hypervisor scratch) follows the same rules as code 0 and shares the same registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_space | input | 3 | Address-space code (0–4 served) |
| req_offset | input | OFF_W | Byte offset within the space |
| req_priv | input | 1 | Privileged mode |
| req_hpriv | input | 1 | Hypervisor mode |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access granted and performed |
| rsp_rdata | output | DATA_W | Load data for a granted read, else 0 |
| rsp_fault_kind | output | 2 | 0 none, 1 privileged action, 2 data-access exception |
| rsp_error | output | 1 | Unsupported space or offset |
| fs_valid | output | 1 | Fault status holds a record |
| fs_write | output | 1 | Recorded fault came from a store |
| fs_ctx | output | 2 | Recorded context type (0 = primary) |
| fs_side | output | 1 | Recorded side-effect bit |
| fs_type | output | 4 | Recorded fault type (8 = illegal space) |

## Verification
The assertions assume that the mode flags, space code and offset are stable and known in every cycle where `req_valid` is high, and that the request bundle does not depend on the response of the same cycle. The bench drives every request field at the falling edge and holds it through the rising edge. It never derives a request from a response in the same cycle. Stimulus keeps offsets within the 12-bit field but deliberately steps just past each window edge (0x38/0x39, 0x1F/0x20, 0x2F/0x30, 0x3BF/0x3C0, 0x3F8/0x400), so every boundary rule is hit from both sides.

// File: rtl/altspace_pkg.sv
package altspace_pkg;

    // Served space codes; 5..7 are not served
    localparam logic [2:0] SP_SCRATCH  = 3'd0;
    localparam logic [2:0] SP_HSCRATCH = 3'd1;
    localparam logic [2:0] SP_QUEUE    = 3'd2;
    localparam logic [2:0] SP_MMUCTX   = 3'd3;
    localparam logic [2:0] SP_DMMU     = 3'd4;

    // Response fault kinds
    localparam logic [1:0] FK_NONE    = 2'd0;
    localparam logic [1:0] FK_PRIVACT = 2'd1;
    localparam logic [1:0] FK_DAX     = 2'd2;

    // Fault status field values
    localparam logic [1:0] CTX_PRIMARY   = 2'd0;
    localparam logic [3:0] FT_ILLEGAL_SP = 4'h8;

    // Window geometry
    localparam int SCR_N     = 8;
    localparam int QUE_N     = 4;
    localparam int IDX_W     = 3;
    localparam int QUE_BASE  = 32'h3C;

    typedef enum logic [1:0] {
        VD_OK,
        VD_PRIVACT,
        VD_DAX,
        VD_UNSUP
    } verdict_e;

    typedef enum logic [2:0] {
        TG_NONE,
        TG_SCR,
        TG_QUE,
        TG_PCTX,
        TG_SCTX,
        TG_PART
    } target_e;

    typedef struct packed {
        verdict_e            verdict;
        target_e             target;
        logic [IDX_W-1:0]    idx;
    } decode_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GRANT,
        ST_FAULT,
        ST_ERROR
    } state_e;

endpackage

// File: rtl/altspace_decode.sv
module altspace_decode
    import altspace_pkg::*;
#(
    parameter int OFF_W = 12
) (
    input  logic [2:0]       space,
    input  logic [OFF_W-1:0] offset,
    input  logic             priv,
    input  logic             hpriv,
    output decode_t          dec
);

    logic [31:0] off32;
    logic        scr_hv_band;
    logic        que_bad_range;
    logic        que_bad_align;

    assign off32 = {{(32-OFF_W){1'b0}}, offset};

    // Scratch slots reserved for hypervisor software
    assign scr_hv_band   = (off32 >= 32'h20) && (off32 < 32'h30);
    // Queue window edges and alignment rule
    assign que_bad_range = (off32 < 32'h3C0) || (off32 > 32'h3F8);
    assign que_bad_align = priv && (off32[3:0] != 4'h0);

    always_comb begin
        dec.verdict = VD_UNSUP;
        dec.target  = TG_NONE;
        dec.idx     = '0;
        unique case (space)
            SP_SCRATCH, SP_HSCRATCH: begin
                if (off32 > 32'h38) begin
                    dec.verdict = VD_DAX;
                end else if (scr_hv_band && !hpriv) begin
                    dec.verdict = VD_DAX;
                end else begin
                    dec.verdict = VD_OK;
                    dec.target  = TG_SCR;
                    dec.idx     = IDX_W'(off32 >> 3);
                end
            end
            SP_QUEUE: begin
                if (!priv && !hpriv) begin
                    dec.verdict = VD_PRIVACT;
                end else if (que_bad_align || que_bad_range) begin
                    dec.verdict = VD_DAX;
                end else begin
                    dec.verdict = VD_OK;
                    dec.target  = TG_QUE;
                    dec.idx     = IDX_W'((off32 >> 4) - QUE_BASE);
                end
            end
            SP_MMUCTX: begin
                if (off32 == 32'h08) begin
                    dec.verdict = VD_OK;
                    dec.target  = TG_PCTX;
                end else if (off32 == 32'h10) begin
                    dec.verdict = VD_OK;
                    dec.target  = TG_SCTX;
                end
            end
            SP_DMMU: begin
                if (off32 == 32'h80) begin
                    dec.verdict = VD_OK;
                    dec.target  = TG_PART;
                end
            end
            default: begin
                dec.verdict = VD_UNSUP;
            end
        endcase
    end

endmodule

// File: rtl/altspace_regfile.sv
module altspace_regfile
    import altspace_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  target_e           target,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int SIDX_W = $clog2(SCR_N);
    localparam int QIDX_W = $clog2(QUE_N);

    logic [DATA_W-1:0] scr_q [SCR_N];
    logic [DATA_W-1:0] que_q [QUE_N];
    logic [DATA_W-1:0] pctx_q;
    logic [DATA_W-1:0] sctx_q;
    logic [DATA_W-1:0] part_q;

    for (genvar g = 0; g < SCR_N; g++) begin : g_scr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                scr_q[g] <= '0;
            end else if (wr_en && target == TG_SCR && idx == IDX_W'(g)) begin
                scr_q[g] <= wdata;
            end
        end
    end

    for (genvar g = 0; g < QUE_N; g++) begin : g_que
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                que_q[g] <= '0;
            end else if (wr_en && target == TG_QUE && idx == IDX_W'(g)) begin
                que_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pctx_q <= '0;
            sctx_q <= '0;
            part_q <= '0;
        end else if (wr_en) begin
            if (target == TG_PCTX) pctx_q <= wdata;
            if (target == TG_SCTX) sctx_q <= wdata;
            if (target == TG_PART) part_q <= wdata;
        end
    end

    always_comb begin
        unique case (target)
            TG_SCR:  rdata = scr_q[idx[SIDX_W-1:0]];
            TG_QUE:  rdata = que_q[idx[QIDX_W-1:0]];
            TG_PCTX: rdata = pctx_q;
            TG_SCTX: rdata = sctx_q;
            TG_PART: rdata = part_q;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/altspace_reg_gate.sv
module altspace_reg_gate
    import altspace_pkg::*;
#(
    parameter int OFF_W  = 12,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_space,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic              req_priv,
    input  logic              req_hpriv,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [1:0]        rsp_fault_kind,
    output logic              rsp_error,
    output logic              fs_valid,
    output logic              fs_write,
    output logic [1:0]        fs_ctx,
    output logic              fs_side,
    output logic [3:0]        fs_type
);

    decode_t           dec;
    state_e            state_q;
    state_e            state_nx;
    logic              rf_we;
    logic [DATA_W-1:0] rf_rdata;
    logic [DATA_W-1:0] rdata_q;
    logic [1:0]        kind_q;
    logic              is_fault;

    altspace_decode #(
        .OFF_W (OFF_W)
    ) u_decode (
        .space  (req_space),
        .offset (req_offset),
        .priv   (req_priv),
        .hpriv  (req_hpriv),
        .dec    (dec)
    );

    assign rf_we    = req_valid && req_write && (dec.verdict == VD_OK);
    assign is_fault = req_valid &&
                      (dec.verdict == VD_PRIVACT || dec.verdict == VD_DAX);

    altspace_regfile #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (rf_we),
        .target (dec.target),
        .idx    (dec.idx),
        .wdata  (req_wdata),
        .rdata  (rf_rdata)
    );

    // Next-state selection
    always_comb begin
        state_nx = ST_IDLE;
        if (req_valid) begin
            unique case (dec.verdict)
                VD_OK:              state_nx = ST_GRANT;
                VD_PRIVACT, VD_DAX: state_nx = ST_FAULT;
                default:            state_nx = ST_ERROR;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Captured response payload and fault status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            kind_q   <= FK_NONE;
            fs_valid <= 1'b0;
            fs_write <= 1'b0;
            fs_ctx   <= CTX_PRIMARY;
            fs_side  <= 1'b0;
            fs_type  <= 4'h0;
        end else begin
            rdata_q <= (req_valid && !req_write && dec.verdict == VD_OK)
                       ? rf_rdata : '0;
            unique case (dec.verdict)
                VD_PRIVACT: kind_q <= FK_PRIVACT;
                VD_DAX:     kind_q <= FK_DAX;
                default:    kind_q <= FK_NONE;
            endcase
            if (is_fault) begin
                fs_valid <= 1'b1;
                fs_write <= req_write;
                fs_ctx   <= CTX_PRIMARY;
                fs_side  <= 1'b1;
                fs_type  <= FT_ILLEGAL_SP;
            end
        end
    end

    // Response outputs
    always_comb begin
        rsp_valid      = 1'b0;
        rsp_grant      = 1'b0;
        rsp_rdata      = '0;
        rsp_fault_kind = FK_NONE;
        rsp_error      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_GRANT: begin
                rsp_valid = 1'b1;
                rsp_grant = 1'b1;
                rsp_rdata = rdata_q;
            end
            ST_FAULT: begin
                rsp_valid      = 1'b1;
                rsp_fault_kind = kind_q;
            end
            ST_ERROR: begin
                rsp_valid = 1'b1;
                rsp_error = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/altspace_reg_gate_chk.sv
module altspace_reg_gate_chk #(
    parameter int OFF_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [2:0]       req_space,
    input logic [OFF_W-1:0] req_offset,
    input logic             req_priv,
    input logic             req_hpriv,
    input logic             rsp_valid,
    input logic             rsp_grant,
    input logic [1:0]       rsp_fault_kind,
    input logic             rsp_error,
    input logic             fs_valid,
    input logic             fs_write,
    input logic [1:0]       fs_ctx,
    input logic             fs_side,
    input logic [3:0]       fs_type
);

    p_resp_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_req_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_one_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_grant, rsp_fault_kind != 2'd0, rsp_error}) == 1);

    p_scr_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_space == 3'd0 || req_space == 3'd1) &&
         req_offset > OFF_W'(12'h038)) |=> rsp_fault_kind == 2'd2);

    p_queue_user_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_space == 3'd2 && !req_priv && !req_hpriv)
        |=> rsp_fault_kind == 2'd1);

    p_unsup_space_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_space >= 3'd5) |=> rsp_error);

    p_fs_record_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault_kind != 2'd0) |->
        (fs_valid && fs_side && fs_ctx == 2'd0 && fs_type == 4'h8));

    p_fs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_fault_kind != 2'd0) |->
        $stable({fs_valid, fs_write, fs_ctx, fs_side, fs_type}));

    p_fs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_space == 3'd2 && !req_priv && !req_hpriv)
        |=> fs_write == $past(req_write));

endmodule

bind altspace_reg_gate altspace_reg_gate_chk #(
    .OFF_W (OFF_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_space      (req_space),
    .req_offset     (req_offset),
    .req_priv       (req_priv),
    .req_hpriv      (req_hpriv),
    .rsp_valid      (rsp_valid),
    .rsp_grant      (rsp_grant),
    .rsp_fault_kind (rsp_fault_kind),
    .rsp_error      (rsp_error),
    .fs_valid       (fs_valid),
    .fs_write       (fs_write),
    .fs_ctx         (fs_ctx),
    .fs_side        (fs_side),
    .fs_type        (fs_type)
);

// File: tb/altspace_reg_gate_bench.sv
`timescale 1ns/1ps
module altspace_reg_gate_bench;

    localparam int OFF_W  = 12;
    localparam int DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [2:0]        req_space = '0;
    logic [OFF_W-1:0]  req_offset = '0;
    logic              req_priv = 1'b0;
    logic              req_hpriv = 1'b0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic              rsp_grant;
    logic [DATA_W-1:0] rsp_rdata;
    logic [1:0]        rsp_fault_kind;
    logic              rsp_error;
    logic              fs_valid;
    logic              fs_write;
    logic [1:0]        fs_ctx;
    logic              fs_side;
    logic [3:0]        fs_type;

    altspace_reg_gate #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_altspace_reg_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_space(req_space), .req_offset(req_offset), .req_priv(req_priv),
        .req_hpriv(req_hpriv), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant), .rsp_rdata(rsp_rdata), .rsp_fault_kind(rsp_fault_kind),
        .rsp_error(rsp_error), .fs_valid(fs_valid), .fs_write(fs_write),
        .fs_ctx(fs_ctx), .fs_side(fs_side), .fs_type(fs_type)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        bit              grant;
        bit [1:0]        kind;
        bit              err;
        bit              wr;
        logic [DATA_W-1:0] rdata;
        string           tag;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    // Bench-side register model built from the requirements
    logic [DATA_W-1:0] m_scr [8];
    logic [DATA_W-1:0] m_que [4];
    logic [DATA_W-1:0] m_pctx = '0;
    logic [DATA_W-1:0] m_sctx = '0;
    logic [DATA_W-1:0] m_part = '0;

    initial begin
        for (int i = 0; i < 8; i++) m_scr[i] = '0;
        for (int i = 0; i < 4; i++) m_que[i] = '0;
    end

    task automatic fail_line(input string tag, input string got, input string want);
        n_errors++;
        $display("FAIL %s actual=%s expected=%s", tag, got, want);
    endtask

    // Driver: drives one request at the falling edge and queues its expectation
    task automatic issue(input bit [2:0] sp, input bit [11:0] off, input bit pv,
                         input bit hv, input bit wr, input logic [DATA_W-1:0] wd,
                         input string tag);
        exp_t e;
        int   sel;      // 0 none,1 scr,2 que,3 pctx,4 sctx,5 part
        int   idx;
        e.grant = 0; e.kind = 0; e.err = 0; e.wr = wr; e.rdata = '0; e.tag = tag;
        sel = 0; idx = 0;
        if (sp == 3'd0 || sp == 3'd1) begin
            if (off > 12'h038) e.kind = 2;
            else if (off >= 12'h020 && off <= 12'h02F && !hv) e.kind = 2;
            else begin sel = 1; idx = int'(off) / 8; end
        end else if (sp == 3'd2) begin
            if (!pv && !hv) e.kind = 1;
            else if ((pv && off[3:0] != 0) || off > 12'h3F8 || off < 12'h3C0) e.kind = 2;
            else begin sel = 2; idx = int'(off) / 16 - 60; end
        end else if (sp == 3'd3) begin
            if (off == 12'h008) sel = 3;
            else if (off == 12'h010) sel = 4;
            else e.err = 1;
        end else if (sp == 3'd4) begin
            if (off == 12'h080) sel = 5;
            else e.err = 1;
        end else begin
            e.err = 1;
        end
        if (sel != 0) begin
            e.grant = 1;
            if (wr) begin
                case (sel)
                    1: m_scr[idx] = wd;
                    2: m_que[idx] = wd;
                    3: m_pctx = wd;
                    4: m_sctx = wd;
                    default: m_part = wd;
                endcase
            end else begin
                case (sel)
                    1: e.rdata = m_scr[idx];
                    2: e.rdata = m_que[idx];
                    3: e.rdata = m_pctx;
                    4: e.rdata = m_sctx;
                    default: e.rdata = m_part;
                endcase
            end
        end
        @(negedge clk);
        req_valid = 1; req_write = wr; req_space = sp; req_offset = off;
        req_priv = pv; req_hpriv = hv; req_wdata = wd;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 0;
        end
    endtask

    // Monitor: compares each response with the oldest expectation
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                n_checks++;
                if (sb.size() == 0) begin
                    fail_line("R1 unexpected response", "rsp_valid=1", "no response");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (rsp_grant !== e.grant || rsp_fault_kind !== e.kind ||
                        rsp_error !== e.err || rsp_rdata !== e.rdata)
                        fail_line(e.tag,
                            $sformatf("g=%0d k=%0d e=%0d d=%h", rsp_grant, rsp_fault_kind, rsp_error, rsp_rdata),
                            $sformatf("g=%0d k=%0d e=%0d d=%h", e.grant, e.kind, e.err, e.rdata));
                    if (e.kind != 0) begin
                        n_checks++;
                        if (fs_valid !== 1 || fs_ctx !== 2'd0 || fs_side !== 1 ||
                            fs_type !== 4'h8 || fs_write !== e.wr)
                            fail_line({"R10 status after ", e.tag},
                                $sformatf("v=%0d c=%0d s=%0d t=%h w=%0d", fs_valid, fs_ctx, fs_side, fs_type, fs_write),
                                $sformatf("v=1 c=0 s=1 t=8 w=%0d", e.wr));
                    end
                end
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            fail_line("watchdog", "hung", "finished");
            finish_run();
        end
    end

    localparam logic [63:0] D0 = 64'h1111_0000_AAAA_0001;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== 0 || fs_valid !== 0)
            fail_line("R1 reset state", $sformatf("v=%0d fs=%0d", rsp_valid, fs_valid), "v=0 fs=0");

        // R2: scratch grants and slot from offset
        issue(0, 12'h000, 0, 0, 1, D0 + 0, "R2 scr wr 0x00");
        issue(0, 12'h008, 0, 0, 1, D0 + 1, "R2 scr wr 0x08");
        issue(0, 12'h018, 1, 0, 1, D0 + 3, "R2 scr wr 0x18");
        issue(0, 12'h030, 0, 0, 1, D0 + 6, "R2 scr wr 0x30");
        issue(0, 12'h038, 0, 0, 1, D0 + 7, "R2 scr wr 0x38");
        issue(0, 12'h01F, 0, 0, 0, '0,     "R2 scr rd 0x1F slot3");
        issue(0, 12'h003, 0, 0, 0, '0,     "R2 scr rd 0x03 slot0");
        issue(0, 12'h038, 0, 0, 0, '0,     "R2 scr rd 0x38");
        idle(2);
        // R3: hypervisor band
        issue(0, 12'h020, 1, 0, 1, 64'hBAD0, "R3 scr 0x20 priv wr");
        issue(0, 12'h02F, 0, 0, 0, '0,       "R3 scr 0x2F user rd");
        issue(0, 12'h020, 0, 1, 0, '0,       "R11 scr 0x20 hv rd after fault");
        issue(0, 12'h028, 0, 1, 1, D0 + 5,   "R3 scr 0x28 hv wr");
        issue(0, 12'h028, 1, 1, 0, '0,       "R3 scr 0x28 hv rd");
        // R4: above the window
        issue(0, 12'h039, 0, 1, 0, '0,       "R4 scr 0x39");
        issue(0, 12'h040, 1, 1, 1, 64'hBAD1, "R4 scr 0x40 wr");
        issue(0, 12'h3F8, 0, 0, 0, '0,       "R4 scr 0x3F8");
        // R12: hypervisor scratch space shares the bank
        issue(1, 12'h008, 0, 0, 0, '0,       "R12 hscr rd 0x08");
        issue(1, 12'h010, 0, 1, 1, D0 + 2,   "R12 hscr wr 0x10");
        issue(0, 12'h010, 0, 0, 0, '0,       "R12 scr rd 0x10");
        issue(1, 12'h039, 0, 1, 0, '0,       "R12 hscr 0x39");
        idle(1);
        // R5: queue needs privilege
        issue(2, 12'h3C0, 0, 0, 1, 64'hBAD2, "R5 que user wr");
        issue(2, 12'h005, 0, 0, 0, '0,       "R5 que user bad offset");
        // R7: queue slots
        issue(2, 12'h3C0, 1, 0, 1, D0 + 16, "R7 que wr 0x3C0");
        issue(2, 12'h3D0, 1, 0, 1, D0 + 17, "R7 que wr 0x3D0");
        issue(2, 12'h3E0, 0, 1, 1, D0 + 18, "R7 que wr 0x3E0");
        issue(2, 12'h3F0, 1, 1, 1, D0 + 19, "R7 que wr 0x3F0");
        issue(2, 12'h3C0, 1, 0, 0, '0,      "R11 que rd 0x3C0 after faulting wr");
        issue(2, 12'h3D0, 0, 1, 0, '0,      "R7 que rd 0x3D0");
        issue(2, 12'h3F8, 0, 1, 0, '0,      "R7 que hv rd 0x3F8 slot3");
        issue(2, 12'h3C8, 0, 1, 0, '0,      "R6 que hv unaligned ok");
        // R6: queue range and alignment
        issue(2, 12'h3C8, 1, 0, 0, '0,      "R6 que priv unaligned");
        issue(2, 12'h3C8, 1, 1, 1, 64'hBAD3, "R6 que priv+hv unaligned");
        issue(2, 12'h3B0, 1, 0, 0, '0,      "R6 que below");
        issue(2, 12'h3BF, 0, 1, 0, '0,      "R6 que below hv");
        issue(2, 12'h400, 1, 1, 0, '0,      "R6 que above");
        issue(2, 12'h3E0, 1, 0, 0, '0,      "R11 que rd 0x3E0 unchanged");
        idle(2);
        // R8: MMU identity registers
        issue(3, 12'h008, 0, 0, 1, 64'h0000_0000_0000_0ABC, "R8 pctx wr");
        issue(3, 12'h010, 0, 0, 1, 64'h0000_0000_0000_0DEF, "R8 sctx wr");
        issue(4, 12'h080, 0, 0, 1, 64'h0000_0000_0000_0007, "R8 part wr");
        issue(3, 12'h018, 1, 1, 1, 64'hBAD4, "R8 mmu 0x18 err");
        issue(4, 12'h088, 0, 0, 1, 64'hBAD5, "R8 dmmu 0x88 err");
        issue(4, 12'h008, 0, 0, 0, '0,       "R8 dmmu 0x08 err");
        issue(3, 12'h080, 0, 0, 0, '0,       "R8 mmu 0x80 err");
        issue(3, 12'h008, 0, 0, 0, '0,       "R11 pctx rd after err wr");
        issue(3, 12'h010, 0, 0, 0, '0,       "R8 sctx rd");
        issue(4, 12'h080, 0, 0, 0, '0,       "R8 part rd");
        // R9: unsupported space codes
        issue(5, 12'h000, 1, 1, 0, '0,       "R9 space 5");
        issue(6, 12'h008, 0, 0, 1, 64'hBAD6, "R9 space 6");
        issue(7, 12'h080, 1, 0, 0, '0,       "R9 space 7");
        issue(0, 12'h008, 0, 0, 0, '0,       "R11 scr rd after errors");
        idle(4);

        n_checks++;
        if (sb.size() != 0)
            fail_line("R1 drain", $sformatf("%0d pending", sb.size()), "0 pending");
        done = 1'b1;
        finish_run();
    end

endmodule